// File: doc/BRIEF.md
# Interlocked Bus Slave Register Port

This block answers a 16-bit asynchronous master/slave bus on behalf of a device that owns four word registers. A master places an address, a two-bit transfer code and, for writes, data on the bus. It then raises its sync strobe. The block brings that strobe into its own clock domain through a synchronizer. It compares the upper address bits with a base address set by a parameter. If they match, it turns the cycle into a single request on a register-file port toward the device logic.

That port is valid/ready in both directions. The block raises `dev_rd_valid` or `dev_wr_valid` together with the register index and, for writes, the data and byte enables. It holds all of these stable until the device raises the matching ready. A device that is not able to take the request simply keeps ready low. This back-pressure stalls the bus handshake and nothing is lost. Only after the device has accepted does the block assert slave sync. For a read it also drives the captured word. Slave sync, and any read data, stay up until the block has seen master sync go low. Because the address, code and data are latched when the cycle is decoded, the master may already put up the next address while the current handshake is still closing.

Top module: `absync_slave`

## Requirements
- R1: While reset is held and right after it, `bus_ssync`, `bus_data_oe`, `dev_rd_valid` and `dev_wr_valid` are 0 and `bus_data_out` is 0.
- R2: A cycle whose address bits [ADDR_W-1:3] differ from `BASE` is ignored: no device request is issued, `bus_ssync` never rises, and no register changes.
- R3: Address bits [2:1] give the register index presented on the device port. Index 0 through 3 address four distinct registers.
- R4: Transfer code with bit 1 = 0 (00 or 01) is a read. The block requests the indexed register and captures `dev_rd_data` in the cycle `dev_rd_ready` is high. It then asserts `bus_ssync` and drives the captured word on `bus_data_out` with `bus_data_oe` = 1.
- R5: Transfer code 10 is a word write. The write request carries the bus data with `dev_wr_be` = 2'b11.
- R6: Transfer code 11 is a byte write. Address bit 0 = 0 gives `dev_wr_be` = 2'b01 (bits 7:0 only). Address bit 0 = 1 gives 2'b10 (bits 15:8 only).
- R7: A request valid stays high, with index, data and enables stable, until its ready is seen. `bus_ssync` rises only after that handshake has completed, and both valids are never high together.
- R8: Once high, `bus_ssync` stays high, with `bus_data_out` unchanged, until master sync has been seen low. It then falls within SYNC_STAGES+2 clock cycles.
- R9: Each assertion of master sync produces exactly one device request. Address, code or data changes after master sync falls do not alter the finished transfer or start another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address lines |
| bus_ctl | input | 2 | Transfer code: 0x read, 10 word write, 11 byte write |
| bus_data_in | input | 16 | Write data from the master |
| bus_data_out | output | 16 | Read data toward the master, 0 when not driving |
| bus_data_oe | output | 1 | Read data drive enable |
| bus_msync | input | 1 | Master sync strobe (asynchronous) |
| bus_ssync | output | 1 | Slave sync response |
| dev_rd_valid | output | 1 | Read request to device |
| dev_rd_ready | input | 1 | Device supplies read data this cycle |
| dev_rd_data | input | 16 | Read data from device |
| dev_wr_valid | output | 1 | Write request to device |
| dev_wr_ready | input | 1 | Device accepts write this cycle |
| dev_wr_data | output | 16 | Write data to device |
| dev_wr_be | output | 2 | Byte enables, bit 1 = bits 15:8 |
| dev_idx | output | 2 | Register index of the current request |

## Verification
The bench aims at byte writes on both lanes. It follows each with word reads, so a design that swapped lanes or wrote the whole word would return a corrupted neighbour byte. It issues cycles to addresses just outside the base window. A loose compare would answer them, and the bench sees that as an extra write or a slave sync where none is due. Device ready is held off for random spans, which catches a slave that asserts sync before acceptance or lets its request drift. After every transfer the master moves the address at once, so a design that re-decodes live lines, or restarts before master sync falls, shows up as a duplicated request.

// File: rtl/absync_pkg.sv
package absync_pkg;
  localparam int DW  = 16;
  localparam int NBE = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_ACK  = 3'd3,
    ST_SKIP = 3'd4
  } st_e;

  typedef struct packed {
    logic           wr;
    logic [1:0]     idx;
    logic [NBE-1:0] be;
    logic [DW-1:0]  data;
  } req_t;
endpackage

// File: rtl/absync_sync.sv
module absync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/absync_decode.sv
module absync_decode
  import absync_pkg::*;
#(
  parameter int              ADDR_W = 18,
  parameter logic [ADDR_W-4:0] BASE = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctl,
  input  logic [DW-1:0]     data,
  output logic              hit,
  output req_t              req
);
  always_comb begin
    hit      = (addr[ADDR_W-1:3] == BASE);
    req.wr   = ctl[1];
    req.idx  = addr[2:1];
    req.data = data;
    if (ctl == 2'b11) req.be = addr[0] ? 2'b10 : 2'b01;
    else              req.be = 2'b11;
  end
endmodule

// File: rtl/absync_ctrl.sv
module absync_ctrl
  import absync_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msync_s,
  input  logic          hit,
  input  req_t          dreq,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_ready,
  output logic          rd_valid,
  output logic          wr_valid,
  output req_t          req_q,
  output logic          ssync,
  output logic          oe,
  output logic [DW-1:0] rdata
);
  st_e           st;
  logic [DW-1:0] rdata_q;
  logic          ssync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      req_q   <= '0;
      rdata_q <= '0;
      ssync_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (msync_s) begin
          if (hit) begin
            req_q <= dreq;
            st    <= dreq.wr ? ST_WR : ST_RD;
          end else begin
            st <= ST_SKIP;
          end
        end
        ST_RD: if (rd_ready) begin
          rdata_q <= rd_data;
          ssync_q <= 1'b1;
          st      <= ST_ACK;
        end
        ST_WR: if (wr_ready) begin
          ssync_q <= 1'b1;
          st      <= ST_ACK;
        end
        ST_ACK: if (!msync_s) begin
          ssync_q <= 1'b0;
          st      <= ST_IDLE;
        end
        ST_SKIP: if (!msync_s) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = (st == ST_RD);
  assign wr_valid = (st == ST_WR);
  assign ssync    = ssync_q;
  assign oe       = ssync_q & ~req_q.wr;
  assign rdata    = oe ? rdata_q : '0;
endmodule

// File: rtl/absync_slave.sv
module absync_slave
  import absync_pkg::*;
#(
  parameter int                ADDR_W      = 18,
  parameter logic [ADDR_W-4:0] BASE        = 15'h7FF0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_ctl,
  input  logic [15:0]       bus_data_in,
  output logic [15:0]       bus_data_out,
  output logic              bus_data_oe,
  input  logic              bus_msync,
  output logic              bus_ssync,
  output logic              dev_rd_valid,
  input  logic              dev_rd_ready,
  input  logic [15:0]       dev_rd_data,
  output logic              dev_wr_valid,
  input  logic              dev_wr_ready,
  output logic [15:0]       dev_wr_data,
  output logic [1:0]        dev_wr_be,
  output logic [1:0]        dev_idx
);
  logic msync_s;
  logic hit;
  req_t dreq;
  req_t req_q;

  absync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_msync), .q(msync_s)
  );

  absync_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .ctl(bus_ctl), .data(bus_data_in), .hit(hit), .req(dreq)
  );

  absync_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .msync_s(msync_s), .hit(hit), .dreq(dreq),
    .rd_ready(dev_rd_ready), .rd_data(dev_rd_data), .wr_ready(dev_wr_ready),
    .rd_valid(dev_rd_valid), .wr_valid(dev_wr_valid), .req_q(req_q),
    .ssync(bus_ssync), .oe(bus_data_oe), .rdata(bus_data_out)
  );

  assign dev_wr_data = req_q.data;
  assign dev_wr_be   = req_q.be;
  assign dev_idx     = req_q.idx;
endmodule

// File: rtl/absync_slave_chk.sv
module absync_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_msync,
  input logic        bus_ssync,
  input logic        bus_data_oe,
  input logic [15:0] bus_data_out,
  input logic        dev_rd_valid,
  input logic        dev_rd_ready,
  input logic        dev_wr_valid,
  input logic        dev_wr_ready,
  input logic [15:0] dev_wr_data,
  input logic [1:0]  dev_wr_be,
  input logic [1:0]  dev_idx
);
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_valid && !dev_wr_ready |=> dev_wr_valid && $stable(dev_wr_data)
      && $stable(dev_wr_be) && $stable(dev_idx));
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd_valid && !dev_rd_ready |=> dev_rd_valid && $stable(dev_idx));
  // R7
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd_valid && dev_wr_valid));
  // R7
  ack_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ssync) |-> $past(dev_rd_valid && dev_rd_ready)
      || $past(dev_wr_valid && dev_wr_ready));
  // R8
  ssync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ssync && bus_msync |=> bus_ssync);
  // R8
  rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ssync |=> !bus_ssync || $stable(bus_data_out));
  // R6
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_valid |-> dev_wr_be != 2'b00);
  // R4
  oe_only_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> bus_ssync);
endmodule

bind absync_slave absync_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_msync(bus_msync), .bus_ssync(bus_ssync),
  .bus_data_oe(bus_data_oe), .bus_data_out(bus_data_out),
  .dev_rd_valid(dev_rd_valid), .dev_rd_ready(dev_rd_ready),
  .dev_wr_valid(dev_wr_valid), .dev_wr_ready(dev_wr_ready),
  .dev_wr_data(dev_wr_data), .dev_wr_be(dev_wr_be), .dev_idx(dev_idx)
);

// File: tb/absync_slave_bench.sv
module absync_slave_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 18;
  localparam logic [14:0] BASE       = 15'h7FF0;
  localparam int          SYNC       = 2;
  localparam int          DESKEW     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0]  bus_ctl = 2'b00;
  logic [15:0] bus_data_in = '0;
  logic [15:0] bus_data_out;
  logic        bus_data_oe, bus_msync = 1'b0, bus_ssync;
  logic        dev_rd_valid, dev_rd_ready = 1'b0;
  logic [15:0] dev_rd_data;
  logic        dev_wr_valid, dev_wr_ready = 1'b0;
  logic [15:0] dev_wr_data;
  logic [1:0]  dev_wr_be, dev_idx;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  absync_slave #(.ADDR_W(ADDR_W), .BASE(BASE), .SYNC_STAGES(SYNC)) u_absync_slave (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ctl(bus_ctl),
    .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
    .bus_data_oe(bus_data_oe), .bus_msync(bus_msync), .bus_ssync(bus_ssync),
    .dev_rd_valid(dev_rd_valid), .dev_rd_ready(dev_rd_ready),
    .dev_rd_data(dev_rd_data), .dev_wr_valid(dev_wr_valid),
    .dev_wr_ready(dev_wr_ready), .dev_wr_data(dev_wr_data),
    .dev_wr_be(dev_wr_be), .dev_idx(dev_idx)
  );

  // device-side register model, driven through the valid/ready port
  logic [15:0] dregs [4];
  logic [15:0] exp_regs [4];
  int   hs_count = 0;
  assign dev_rd_data = dregs[dev_idx];

  always @(posedge clk) begin
    if (dev_wr_valid && dev_wr_ready) begin
      if (dev_wr_be[0]) dregs[dev_idx][7:0]  <= dev_wr_data[7:0];
      if (dev_wr_be[1]) dregs[dev_idx][15:8] <= dev_wr_data[15:8];
    end
    if ((dev_wr_valid && dev_wr_ready) || (dev_rd_valid && dev_rd_ready))
      hs_count <= hs_count + 1;
  end

  always @(negedge clk) begin
    dev_rd_ready <= ($urandom % 3) == 0;
    dev_wr_ready <= ($urandom % 3) == 0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic [1:0] ctl, input bit a0);
    if (ctl != 2'b11) return d;
    if (a0) return {d[15:8], old[7:0]};
    return {old[15:8], d[7:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input bit hit, input logic [1:0] idx,
                                                 input bit a0);
    logic [14:0] up;
    up = BASE;
    if (!hit) up = BASE ^ (15'd1 << ($urandom % 15));
    return {up, idx, a0};
  endfunction

  // one bus transfer; expected values come from exp_regs
  task automatic xfer(input bit hit, input logic [1:0] idx, input bit a0,
                      input logic [1:0] ctl, input logic [15:0] d);
    int hs0, waitc;
    logic [15:0] first;
    string tag;
    hs0 = hs_count;
    @(negedge clk);
    bus_addr = mk_addr(hit, idx, a0);
    bus_ctl = ctl;
    bus_data_in = d;
    @(negedge clk);
    bus_msync = 1'b1;
    waitc = 0;
    while (!bus_ssync && waitc < 60) begin @(negedge clk); waitc++; end
    if (!hit) begin
      check(!bus_ssync, "R2 no ssync on miss", bus_ssync, 0);
      bus_msync = 1'b0;
      repeat (SYNC + 3) @(negedge clk);
      check(hs_count == hs0, "R2 no device request on miss", hs_count - hs0, 0);
      return;
    end
    check(bus_ssync, "R7 ssync after accept", bus_ssync, 1);
    check(hs_count == hs0 + 1, "R7 handshake before ssync", hs_count - hs0, 1);
    first = bus_data_out;
    repeat (DESKEW) @(negedge clk);
    if (!ctl[1]) begin
      tag = (idx == 2'd0) ? "R4 read idx0" : "R3 R4 read indexed";
      check(bus_data_oe, "R4 read drive enable", bus_data_oe, 1);
      check(bus_data_out == exp_regs[idx], tag, bus_data_out, exp_regs[idx]);
      check(bus_data_out == first, "R8 read data stable", bus_data_out, first);
    end else begin
      check(!bus_data_oe, "R5 no drive on write", bus_data_oe, 0);
      exp_regs[idx] = merge(exp_regs[idx], d, ctl, a0);
    end
    bus_msync = 1'b0;
    @(negedge clk);
    bus_addr = mk_addr($urandom % 2, 2'($urandom), 1'($urandom));
    bus_ctl = 2'($urandom);
    bus_data_in = 16'($urandom);
    check(bus_ssync, "R8 ssync held past msync drop", bus_ssync, 1);
    waitc = 1;
    while (bus_ssync && waitc < 10) begin @(negedge clk); waitc++; end
    check(!bus_ssync && waitc <= SYNC + 2, "R8 ssync release latency", waitc, SYNC + 2);
    repeat (3) @(negedge clk);
    check(hs_count == hs0 + 1, "R9 single request per strobe", hs_count - hs0, 1);
  endtask

  task automatic read_all(input string why);
    for (int i = 0; i < 4; i++) xfer(1'b1, 2'(i), 1'b0, 2'b00, 16'h0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin
      dregs[i] = 16'($urandom);
      exp_regs[i] = dregs[i];
    end
    repeat (4) @(negedge clk);
    check(!bus_ssync && !bus_data_oe && bus_data_out == 0 && !dev_rd_valid
          && !dev_wr_valid, "R1 reset outputs",
          {bus_ssync, bus_data_oe, dev_rd_valid, dev_wr_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!bus_ssync && bus_data_out == 0, "R1 after reset", bus_ssync, 0);

    // directed: word writes then byte lanes
    for (int i = 0; i < 4; i++) xfer(1'b1, 2'(i), 1'b0, 2'b10, 16'h1111 * (i + 1)); // R5
    read_all("R3");
    xfer(1'b1, 2'd2, 1'b0, 2'b11, 16'hABCD); // R6 low lane
    xfer(1'b1, 2'd2, 1'b1, 2'b11, 16'h5A00); // R6 high lane
    xfer(1'b1, 2'd2, 1'b0, 2'b00, 16'h0);
    xfer(1'b1, 2'd1, 1'b0, 2'b01, 16'h0);    // R4 code 01 is a read
    // directed: misses must touch nothing
    xfer(1'b0, 2'd3, 1'b0, 2'b10, 16'hDEAD); // R2
    xfer(1'b0, 2'd0, 1'b1, 2'b11, 16'hBEEF); // R2
    read_all("R2");

    for (int n = 0; n < 300; n++) begin
      bit hit;
      hit = ($urandom % 10) != 0;
      xfer(hit, 2'($urandom), 1'($urandom), 2'($urandom), 16'($urandom));
    end
    read_all("R9");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule